// File: doc/BRIEF.md
# Tile Row Chunk Extractor

The block holds a small two-dimensional tile: up to 16 rows of 64 bytes each. A write port stores one whole row per cycle. A read port takes one 32-bit selector and returns one 64-byte slice of one row. The selector carries two fields. The low half picks the row. The high half picks a 64-byte chunk inside that row.

Two configuration inputs give the live shape of the tile: how many rows are valid and how many bytes of each row are valid. Bytes past the valid width come back as zero. Rows past the valid count come back as all zero.

A mode input picks one of two behaviours:
- **Raw move:** the stored bytes are passed through unchanged.
- **Convert:** each 32-bit lane is read as a two's-complement integer and turned into an IEEE single-precision value, using round-to-nearest-even. No exception flags are produced.

Zero-filling in raw move works per byte. In convert mode it works per 32-bit lane. Results are registered and appear one cycle after the request, together with a valid strobe.

Top module: `tile_row_extract`

## Requirements
- R1: `rdSel[15:0]` is the row index. `rdSel[31:16]` is the chunk number, and the byte offset into the row is the chunk number times 64.
- R2: When `rdMode`=0 (raw), output byte i (bits 8i+7:8i) equals stored byte offset+i of the selected row if offset+i < the column byte count. Otherwise it is zero. Any chunk number other than 0 therefore returns all zero.
- R3: When `rdMode`=1 (convert), output lane i (bits 32i+31:32i) is zero if i + offset/4 >= floor(column bytes / 4). Otherwise it holds the conversion of stored lane offset/4+i.
- R4: The conversion uses round-to-nearest-even and is exact for magnitudes up to 2^24. Examples:

  | Integer input | Single-precision result |
  |---|---|
  | 0 | 0x00000000 |
  | -2^31 | 0xCF000000 |
  | 2^24+1 | 0x4B800000 |
  | 2^24+3 | 0x4B800002 |
  | 2^31-1 | 0x4F000000 |
- R5: A row index at or above `cfgRows`, or at or above 16, returns all zeros in both modes.
- R6: A `cfgColBytes` value above 64 behaves exactly as 64.
- R7: `rdValid` is high in exactly the cycle after a cycle with `rdReq` high. `rdData` carries that request's result in the same cycle.
- R8: `rdData` keeps its value in any cycle that follows a cycle without `rdReq`.
- R9: With `wrEn` high, the whole row `wrRow` is written with `wrData` at the clock edge. A read of the same row in the same cycle returns the contents from before the write.
- R10: Reset clears `rdValid`, `rdData` and every stored row to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Row write strobe |
| wrRow | input | 4 | Row to write |
| wrData | input | 512 | Row contents, byte 0 in bits 7:0 |
| cfgRows | input | 5 | Number of valid rows (0 to 16) |
| cfgColBytes | input | 7 | Number of valid bytes per row |
| rdReq | input | 1 | Read request |
| rdMode | input | 1 | 0 raw move, 1 integer-to-float |
| rdSel | input | 32 | Chunk number (31:16) and row index (15:0) |
| rdValid | output | 1 | Result valid, one cycle after request |
| rdData | output | 512 | Result vector |

## Verification
The hardest situation to reach is a column width that is not a multiple of four, read in convert mode. There, partial bytes are kept in raw mode but dropped in convert mode, so the two mask granularities disagree on the same row. The stimulus sweeps every column width from 0 to 64 in both modes over one patterned row, so each boundary is hit on both sides.

Rounding ties need integer values chosen so that the dropped bits are exactly one half. A fixed row of such values is therefore written and checked lane by lane against hand-derived encodings, alongside pseudo-random rows.

// File: rtl/tile_row_pkg.sv
package tile_row_pkg;
  localparam int TILE_ROWS = 16;
  localparam int TILE_ROW_BYTES = 64;

  typedef enum logic {
    MODE_RAW = 1'b0,
    MODE_I2F = 1'b1
  } rd_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrGo;
    logic rdGo;
    logic cvtSel;
    logic rowHit;
  } ctrl_strobe_t;
endpackage

// File: rtl/tile_i2f.sv
module tile_i2f (
  input  logic [31:0] intIn,
  output logic [31:0] fltOut
);
  logic        neg;
  logic [31:0] mag;
  logic [4:0]  lead;
  logic [31:0] norm;
  logic [23:0] kept;
  logic        rndBit;
  logic        stkBit;
  logic        bump;
  logic [24:0] sum;
  logic [7:0]  expo;
  logic [22:0] frac;

  always_comb begin
    neg  = intIn[31];
    mag  = neg ? (~intIn + 32'd1) : intIn;
    lead = 5'd0;
    for (int k = 0; k < 32; k++) begin
      if (mag[k]) lead = 5'(k);
    end
    norm   = mag << (5'd31 - lead);
    kept   = norm[31:8];
    rndBit = norm[7];
    stkBit = |norm[6:0];
    bump   = rndBit & (stkBit | kept[0]);
    sum    = {1'b0, kept} + {24'd0, bump};
    expo   = 8'd127 + {3'd0, lead} + {7'd0, sum[24]};
    frac   = sum[24] ? sum[23:1] : sum[22:0];
    if (mag == 32'd0) fltOut = 32'd0;
    else              fltOut = {neg, expo, frac};
  end
endmodule

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import tile_row_pkg::*;
#(
  parameter int ROWS      = TILE_ROWS,
  parameter int ROW_BYTES = TILE_ROW_BYTES,
  localparam int RW       = $clog2(ROWS),
  localparam int CRW      = $clog2(ROWS + 1),
  localparam int CCW      = $clog2(ROW_BYTES + 1),
  localparam int LANES    = ROW_BYTES / 4,
  localparam int OFFW     = 16 + $clog2(ROW_BYTES) + 1
) (
  input  logic                 wrEn,
  input  logic                 rdReq,
  input  logic                 rdMode,
  input  logic [31:0]          rdSel,
  input  logic [CRW-1:0]       cfgRows,
  input  logic [CCW-1:0]       cfgColBytes,
  output ctrl_strobe_t         strobe,
  output logic [RW-1:0]        rdRow,
  output logic [ROW_BYTES-1:0] keepByte
);
  logic [15:0]          rowIdx;
  logic [15:0]          chunkNum;
  logic [OFFW-1:0]      offset;
  logic [OFFW-1:0]      colEff;
  logic [ROW_BYTES-1:0] rawKeep;
  logic [LANES-1:0]     laneKeep;
  rd_mode_e             modeSel;

  assign rowIdx   = rdSel[15:0];
  assign chunkNum = rdSel[31:16];
  assign offset   = OFFW'(chunkNum) * OFFW'(ROW_BYTES);
  assign colEff   = (OFFW'(cfgColBytes) > OFFW'(ROW_BYTES)) ? OFFW'(ROW_BYTES)
                                                           : OFFW'(cfgColBytes);
  assign modeSel  = rd_mode_e'(rdMode);
  assign rdRow    = rowIdx[RW-1:0];

  generate
    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
      assign rawKeep[b] = (offset + OFFW'(b)) < colEff;
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign laneKeep[l] = (OFFW'(l) + (offset >> 2)) < (colEff >> 2);
    end
  endgenerate

  always_comb begin
    for (int b = 0; b < ROW_BYTES; b++) begin
      keepByte[b] = (modeSel == MODE_I2F) ? laneKeep[b/4] : rawKeep[b];
    end
  end

  assign strobe.wrGo   = wrEn;
  assign strobe.rdGo   = rdReq;
  assign strobe.cvtSel = (modeSel == MODE_I2F);
  assign strobe.rowHit = (32'(rowIdx) < 32'(cfgRows)) && (32'(rowIdx) < ROWS);
endmodule

// File: rtl/tile_dpath.sv
module tile_dpath
  import tile_row_pkg::*;
#(
  parameter int ROWS      = TILE_ROWS,
  parameter int ROW_BYTES = TILE_ROW_BYTES,
  localparam int RW       = $clog2(ROWS),
  localparam int ROW_BITS = ROW_BYTES * 8,
  localparam int LANES    = ROW_BYTES / 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobe,
  input  logic [RW-1:0]        wrRow,
  input  logic [ROW_BITS-1:0]  wrData,
  input  logic [RW-1:0]        rdRow,
  input  logic [ROW_BYTES-1:0] keepByte,
  output logic                 rdValid,
  output logic [ROW_BITS-1:0]  rdData
);
  logic [ROW_BITS-1:0] tileMem [ROWS];
  logic [ROW_BITS-1:0] rowWord;
  logic [ROW_BITS-1:0] cvtWord;
  logic [ROW_BITS-1:0] pickWord;
  logic [ROW_BITS-1:0] maskWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) tileMem[r] <= '0;
    end else if (strobe.wrGo) begin
      tileMem[wrRow] <= wrData;
    end
  end

  assign rowWord = tileMem[rdRow];

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_cvt
      tile_i2f u_i2f (
        .intIn (rowWord[32*l +: 32]),
        .fltOut(cvtWord[32*l +: 32])
      );
    end
  endgenerate

  assign pickWord = strobe.cvtSel ? cvtWord : rowWord;

  always_comb begin
    for (int b = 0; b < ROW_BYTES; b++) begin
      maskWord[8*b +: 8] = (keepByte[b] && strobe.rowHit) ? pickWord[8*b +: 8] : 8'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdGo;
      if (strobe.rdGo) rdData <= maskWord;
    end
  end
endmodule

// File: rtl/tile_row_extract.sv
module tile_row_extract
  import tile_row_pkg::*;
#(
  parameter int ROWS      = TILE_ROWS,
  parameter int ROW_BYTES = TILE_ROW_BYTES,
  localparam int RW       = $clog2(ROWS),
  localparam int CRW      = $clog2(ROWS + 1),
  localparam int CCW      = $clog2(ROW_BYTES + 1),
  localparam int ROW_BITS = ROW_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [RW-1:0]       wrRow,
  input  logic [ROW_BITS-1:0] wrData,
  input  logic [CRW-1:0]      cfgRows,
  input  logic [CCW-1:0]      cfgColBytes,
  input  logic                rdReq,
  input  logic                rdMode,
  input  logic [31:0]         rdSel,
  output logic                rdValid,
  output logic [ROW_BITS-1:0] rdData
);
  ctrl_strobe_t         strobe;
  logic [RW-1:0]        rdRow;
  logic [ROW_BYTES-1:0] keepByte;

  tile_ctrl #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_ctrl (
    .wrEn       (wrEn),
    .rdReq      (rdReq),
    .rdMode     (rdMode),
    .rdSel      (rdSel),
    .cfgRows    (cfgRows),
    .cfgColBytes(cfgColBytes),
    .strobe     (strobe),
    .rdRow      (rdRow),
    .keepByte   (keepByte)
  );

  tile_dpath #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrRow   (wrRow),
    .wrData  (wrData),
    .rdRow   (rdRow),
    .keepByte(keepByte),
    .rdValid (rdValid),
    .rdData  (rdData)
  );
endmodule

// File: rtl/tile_row_extract_chk.sv
module tile_row_extract_chk #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  localparam int CRW      = $clog2(ROWS + 1),
  localparam int CCW      = $clog2(ROW_BYTES + 1),
  localparam int ROW_BITS = ROW_BYTES * 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [CRW-1:0]      cfgRows,
  input logic [CCW-1:0]      cfgColBytes,
  input logic                rdReq,
  input logic                rdMode,
  input logic [31:0]         rdSel,
  input logic                rdValid,
  input logic [ROW_BITS-1:0] rdData
);
  p_valid_after_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(rdData));

  p_row_miss_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (32'(rdSel[15:0]) >= 32'(cfgRows))) |=> (rdData == '0));

  p_far_chunk_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (rdSel[31:16] != 16'd0)) |=> (rdData == '0));

  p_raw_last_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdMode && (32'(cfgColBytes) < ROW_BYTES))
      |=> (rdData[ROW_BITS-1 -: 8] == 8'd0));
endmodule

bind tile_row_extract tile_row_extract_chk #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgRows    (cfgRows),
  .cfgColBytes(cfgColBytes),
  .rdReq      (rdReq),
  .rdMode     (rdMode),
  .rdSel      (rdSel),
  .rdValid    (rdValid),
  .rdData     (rdData)
);

// File: tb/tile_row_extract_bench.sv
module tile_row_extract_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [3:0]   wrRow;
  logic [511:0] wrData;
  logic [4:0]   cfgRows;
  logic [6:0]   cfgColBytes;
  logic         rdReq;
  logic         rdMode;
  logic [31:0]  rdSel;
  logic         rdValid;
  logic [511:0] rdData;

  int vectors = 0;
  int misses  = 0;

  logic [511:0] model [16];
  logic         expValid;
  logic [511:0] expData;
  logic [31:0]  seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_row_extract u_tile_row_extract (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRow(wrRow), .wrData(wrData),
    .cfgRows(cfgRows), .cfgColBytes(cfgColBytes), .rdReq(rdReq),
    .rdMode(rdMode), .rdSel(rdSel), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Arithmetic reference for the integer-to-single conversion
  function automatic logic [31:0] refConv(input logic [31:0] raw);
    longint v, mag, q, rem, half, scale;
    int p, sh;
    logic s;
    v = longint'($signed(raw));
    if (v == 0) return 32'd0;
    s = (v < 0);
    mag = s ? -v : v;
    p = 0;
    while ((longint'(1) << (p + 1)) <= mag) p++;
    if (p <= 23) begin
      q = mag * (longint'(1) << (23 - p));
    end else begin
      sh = p - 23;
      scale = longint'(1) << sh;
      q = mag / scale;
      rem = mag % scale;
      half = scale / 2;
      if (rem > half || (rem == half && (q % 2) == 1)) q++;
      if (q == (longint'(1) << 24)) begin
        q = q / 2;
        p++;
      end
    end
    return {s, 8'(127 + p), 23'(q - (longint'(1) << 23))};
  endfunction

  function automatic logic [511:0] refRead(input logic md, input logic [31:0] sel,
                                           input int rows, input int col);
    logic [511:0] r;
    int row, off, c;
    r = '0;
    row = int'(sel[15:0]);
    off = int'(sel[31:16]) * 64;
    c = (col > 64) ? 64 : col;
    if (row >= rows || row >= 16) return r;
    if (!md) begin
      for (int i = 0; i < 64; i++)
        if (off + i < c && off + i < 64) r[8*i +: 8] = model[row][8*(off+i) +: 8];
    end else begin
      for (int i = 0; i < 16; i++)
        if (i + off/4 < c/4) r[32*i +: 32] = refConv(model[row][32*(i + off/4) +: 32]);
    end
    return r;
  endfunction

  task automatic step(input logic we, input int wr, input logic [511:0] wd,
                      input logic rq, input logic md, input logic [31:0] sel,
                      input int rows, input int col, input string tag);
    wrEn = we; wrRow = 4'(wr); wrData = wd;
    rdReq = rq; rdMode = md; rdSel = sel;
    cfgRows = 5'(rows); cfgColBytes = 7'(col);
    expValid = rq;
    if (rq) expData = refRead(md, sel, rows, col);
    if (we) model[wr] = wd;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (rdValid !== expValid || rdData !== expData) begin
      misses++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, rdValid, rdData, expValid, expData);
    end
  endtask

  task automatic laneCheck(input int lane, input logic [31:0] want);
    vectors++;
    if (rdData[32*lane +: 32] !== want) begin
      misses++;
      $display("FAIL R4 lane %0d: got %h expected %h", lane, rdData[32*lane +: 32], want);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [511:0] w;
    for (int r = 0; r < 16; r++) model[r] = '0;
    rstN = 1'b0; wrEn = 0; wrRow = 0; wrData = '0; rdReq = 0; rdMode = 0;
    rdSel = '0; cfgRows = 0; cfgColBytes = 0;
    expValid = 1'b0; expData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    vectors++;
    if (rdValid !== 1'b0 || rdData !== '0) begin
      misses++;
      $display("FAIL R10: valid=%0b data=%h expected 0", rdValid, rdData);
    end
    rstN = 1'b1;
    step(0, 0, '0, 1, 0, 32'd5, 16, 64, "R10 storage cleared");

    // R9: fill rows with patterns; same-cycle read returns old contents
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < 16; i++) w[32*i +: 32] = nextRand();
      step(1, r, w, 1, 0, 32'(r), 16, 64, "R9 write with same-row read");
      step(0, 0, '0, 1, 0, 32'(r), 16, 64, "R9 readback");
    end

    // R4: rounding corner row
    w = '0;
    w[32*0 +: 32] = 32'd0;          w[32*1 +: 32] = 32'd1;
    w[32*2 +: 32] = 32'hFFFF_FFFF;  w[32*3 +: 32] = 32'd16777217;
    w[32*4 +: 32] = 32'd16777219;   w[32*5 +: 32] = 32'h8000_0000;
    w[32*6 +: 32] = 32'h7FFF_FFFF;  w[32*7 +: 32] = 32'd16777216;
    w[32*8 +: 32] = 32'd3;          w[32*9 +: 32] = 32'd33554435;
    for (int i = 10; i < 16; i++) w[32*i +: 32] = nextRand();
    step(1, 3, w, 0, 0, 32'd0, 16, 64, "R9 write corner row");
    step(0, 0, '0, 1, 1, 32'd3, 16, 64, "R4 convert corner row");
    laneCheck(0, 32'h0000_0000); laneCheck(1, 32'h3F80_0000);
    laneCheck(2, 32'hBF80_0000); laneCheck(3, 32'h4B80_0000);
    laneCheck(4, 32'h4B80_0002); laneCheck(5, 32'hCF00_0000);
    laneCheck(6, 32'h4F00_0000); laneCheck(7, 32'h4B80_0000);
    laneCheck(8, 32'h4040_0000); laneCheck(9, 32'h4C00_0001);

    // R2 R3: sweep every column width in both modes
    for (int c = 0; c <= 64; c++) begin
      step(0, 0, '0, 1, 0, 32'd7, 16, c, "R2 raw column sweep");
      step(0, 0, '0, 1, 1, 32'd7, 16, c, "R3 convert column sweep");
    end
    // R6: oversize column counts
    step(0, 0, '0, 1, 0, 32'd9, 16, 65, "R6 col 65 raw");
    step(0, 0, '0, 1, 1, 32'd9, 16, 127, "R6 col 127 convert");
    step(0, 0, '0, 1, 0, 32'h0001_0009, 16, 127, "R6 col 127 chunk 1");

    // R1: chunk numbers
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ch;
      ch = (k == 3) ? 16'hFFFF : 16'(k);
      step(0, 0, '0, 1, 0, {ch, 16'd2}, 16, 64, "R1 chunk raw");
      step(0, 0, '0, 1, 1, {ch, 16'd2}, 16, 64, "R1 chunk convert");
    end

    // R5: row count boundaries
    step(0, 0, '0, 1, 0, 32'd4, 5, 64, "R5 last valid row");
    step(0, 0, '0, 1, 0, 32'd5, 5, 64, "R5 first invalid row");
    step(0, 0, '0, 1, 1, 32'd0, 0, 64, "R5 zero rows");
    step(0, 0, '0, 1, 0, 32'd16, 16, 64, "R5 row 16");
    step(0, 0, '0, 1, 1, 32'h0000_FFFF, 16, 64, "R5 row 65535");

    // R7 R8: gaps and hold
    step(0, 0, '0, 1, 0, 32'd11, 16, 64, "R7 request");
    step(0, 0, '0, 0, 1, 32'd1, 16, 0, "R8 hold, idle");
    step(0, 0, '0, 0, 0, 32'd2, 3, 10, "R8 hold, idle again");

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      a = nextRand();
      b = nextRand();
      for (int i = 0; i < 16; i++) w[32*i +: 32] = nextRand();
      step(a[0] & a[1], int'(a[7:4]), w, a[2] | a[3], a[8],
           {14'd0, b[17:16] & {2{b[18]}}, 11'd0, b[4:0]},
           int'(b[12:8]) % 17, int'(b[30:24]), "R2 R3 R5 R9 mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule